// File: doc/BRIEF.md
# Masked Multichannel ADC Scan Sequencer

This block sits on a 16-bit register bus and keeps an external four-input delta-sigma converter busy. It scans up to six logical analog channels without software help and keeps the latest signed 16-bit result of each one in a read-only register. Software sets a control word (gain, rate and which board pin carries the analog-mux select) and a channel-enable mask. It then just reads results.

Two logical channels are differential and map straight onto converter inputs 1 and 2. The other four are single-ended and share converter inputs 3 and 4 through external analog muxes. Those muxes are steered by one select level, which the block drives onto the board pin chosen in the control word. For each enabled channel the sequencer issues two requests on a byte-level transaction port. The first writes a one-shot configuration byte. After a wait matched to the selected rate, the second reads three bytes back. The sample is kept only when the returned status says the conversion is fresh.

Top module: `adc_scan_seq`

## Requirements
- R1: Word offset 0x0 reads `{8'hAD, 2'b00, ctrl[5:0]}`, where ctrl bits 5-4 are the pin route, bits 3-2 the rate code and bits 1-0 the gain code. `bus_rdata` shows the word addressed in the previous cycle. Control resets to 0.
- R2: Offset 0x2 is a 16-bit read/write mask that resets to 0. Bit k (k = 0..5) enables logical channel k+1.
- R3: While the mask bits 5-0 are all zero and no transaction is pending, `xact_req` stays low.
- R4: Each channel starts with a write request (`xact_rd`=0) carrying `{1, in[1:0], 0, rate[1:0], gain[1:0]}`. `in` is 0 for channel 1, 1 for channel 2, 2 for channels 3/4 and 3 for channels 5/6.
- R5: The select level is 0 for channels 1, 2, 3 and 5 and 1 for channels 4 and 6. It appears on `mux_pins[0]` when the route is 1 and on `mux_pins[1]` when the route is 2. With route 0 or 3, both pins stay low.
- R6: Enabled channels are visited in ascending order, wrapping from 6 to 1. The scan begins at channel 1 after reset.
- R7: The read request (`xact_rd`=1) is raised W cycles after the clock edge that accepts the write's `xact_done`. W is WAIT_FAST for rate code 0, WAIT_MID for code 1 and WAIT_SLOW for codes 2 and 3.
- R8: On the read's `xact_done`, bytes `xact_rbytes[23:8]` become the channel's result when status bit `xact_rbytes[7]` is 0. When that bit is 1, the result is left unchanged.
- R9: The result register of a channel whose mask bit is 0 keeps its previous value.
- R10: A mask write takes effect at the next channel boundary. A channel whose write request is already out still gets its read and store.
- R11: Offsets 0x4 to 0xE read channels 1 to 6 and ignore bus writes. Control bits 15-6 ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset of the register word |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Registered read data for the previous cycle's address |
| xact_req | output | 1 | Transaction request, held until `xact_done` |
| xact_rd | output | 1 | 1: three-byte read, 0: one-byte configuration write |
| xact_wbyte | output | 8 | Configuration byte for a write request |
| xact_done | input | 1 | One-cycle completion pulse of the current transaction |
| xact_rbytes | input | 24 | Read bytes: sample high, sample low, status (bit 7 = stale) |
| mux_pins | output | NUM_SEL_PINS | Candidate board pins for the analog-mux select |

## Verification
The bench drives a sparse mask (channels 1, 3, 4, 6). It checks that order, configuration bytes and pin levels follow the round-robin sequence. A picker that forgot to wrap, or a wrong input code for the shared inputs, would show up as a wrong byte or a missing channel. It measures the gap between write completion and read request at three rate codes, which catches an off-by-one in the wait counter, and it moves the select level between pins by route code. It also rewrites the mask while a write is out: a design that aborted the channel would lose one read. A design that ignored the status bit, touched masked channels or let bus writes reach results would return changed registers.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int NUM_CH = 6;
  localparam int CH_W = $clog2(NUM_CH);
  localparam logic [7:0] CORE_ID = 8'hAD;

  typedef struct packed {
    logic [1:0] route;
    logic [1:0] rate;
    logic [1:0] gain;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CFG,
    ST_WAIT,
    ST_READ
  } scan_state_e;

  // converter input code for a logical channel index (0-based)
  function automatic logic [1:0] conv_input(input logic [CH_W-1:0] ch);
    if (ch < CH_W'(2)) return ch[1:0];
    else if (ch < CH_W'(4)) return 2'd2;
    else return 2'd3;
  endfunction

  // external mux level: high for the second channel of a shared pair
  function automatic logic mux_level(input logic [CH_W-1:0] ch);
    return (ch >= CH_W'(2)) && ch[0];
  endfunction

  function automatic logic [7:0] cfg_byte(input logic [1:0] in_code,
                                          input logic [1:0] rate,
                                          input logic [1:0] gain);
    return {1'b1, in_code, 1'b0, rate, gain};
  endfunction

endpackage

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
  import adc_scan_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int N_CH   = NUM_CH,
  localparam int SLOT_W = $clog2(N_CH),
  localparam int WORD_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output ctrl_t             ctrl,
  output logic [N_CH-1:0]   mask,
  input  logic              res_we,
  input  logic [SLOT_W-1:0] res_idx,
  input  logic [DATA_W-1:0] res_data
);

  logic [DATA_W-1:0] res_mem [N_CH];
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] mask_q;
  logic [WORD_W-1:0] word;
  logic [SLOT_W-1:0] slot;
  logic              slot_ok;

  assign word    = bus_addr[ADDR_W-1:1];
  assign slot    = SLOT_W'(word - WORD_W'(2));
  assign slot_ok = (word >= WORD_W'(2)) && (int'(word) < 2 + N_CH);

  // result storage: single write port from the sequencer, no reset
  always_ff @(posedge clk) begin
    if (res_we) res_mem[res_idx] <= res_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      mask_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_we) begin
        case (word)
          WORD_W'(0): ctrl_q <= ctrl_t'(bus_wdata[5:0]);
          WORD_W'(1): mask_q <= bus_wdata;
          default: ;
        endcase
      end
      case (word)
        WORD_W'(0): bus_rdata <= DATA_W'({CORE_ID, 2'b00, ctrl_q});
        WORD_W'(1): bus_rdata <= mask_q;
        default:    bus_rdata <= slot_ok ? res_mem[slot] : '0;
      endcase
    end
  end

  assign ctrl = ctrl_q;
  assign mask = mask_q[N_CH-1:0];

endmodule

// File: rtl/adc_scan_pick.sv
module adc_scan_pick #(
  parameter int N_CH = 6,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0] mask,
  input  logic [CH_W-1:0] cur,
  output logic [CH_W-1:0] nxt,
  output logic            any
);

  logic [CH_W-1:0] cand [N_CH];
  logic [N_CH-1:0] hit;

  // candidate k is the channel k+1 steps after the current one
  for (genvar k = 0; k < N_CH; k++) begin : g_cand
    logic [CH_W:0] sum;
    assign sum     = {1'b0, cur} + (CH_W+1)'(k + 1);
    assign cand[k] = (sum >= (CH_W+1)'(N_CH)) ? CH_W'(sum - (CH_W+1)'(N_CH))
                                              : sum[CH_W-1:0];
    assign hit[k]  = mask[cand[k]];
  end

  always_comb begin
    any = 1'b0;
    nxt = cur;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (hit[i]) begin
        nxt = cand[i];
        any = 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int N_CH      = NUM_CH,
  parameter int DATA_W    = 16,
  parameter int WAIT_FAST = 24,
  parameter int WAIT_MID  = 48,
  parameter int WAIT_SLOW = 96,
  localparam int CH_W     = $clog2(N_CH),
  localparam int WAIT_MAX = (WAIT_SLOW > WAIT_MID) ?
                            ((WAIT_SLOW > WAIT_FAST) ? WAIT_SLOW : WAIT_FAST) :
                            ((WAIT_MID > WAIT_FAST) ? WAIT_MID : WAIT_FAST),
  localparam int CNT_W    = $clog2(WAIT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        rate,
  input  logic [1:0]        gain,
  input  logic              pick_any,
  input  logic [CH_W-1:0]   pick_nxt,
  output logic [CH_W-1:0]   cur,
  output logic              idle,
  output logic              xact_req,
  output logic              xact_rd,
  output logic [7:0]        xact_wbyte,
  input  logic              xact_done,
  input  logic [DATA_W-1:0] rd_sample,
  input  logic              rd_stale,
  output logic              sel_level,
  output logic              res_we,
  output logic [CH_W-1:0]   res_idx,
  output logic [DATA_W-1:0] res_data
);

  scan_state_e     st;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       rate_q;

  function automatic logic [CNT_W-1:0] wait_len(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(WAIT_FAST);
      2'd1:    return CNT_W'(WAIT_MID);
      default: return CNT_W'(WAIT_SLOW);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cur        <= CH_W'(N_CH - 1);
      cnt        <= '0;
      rate_q     <= '0;
      xact_req   <= 1'b0;
      xact_rd    <= 1'b0;
      xact_wbyte <= '0;
      sel_level  <= 1'b0;
      res_we     <= 1'b0;
      res_idx    <= '0;
      res_data   <= '0;
    end else begin
      res_we <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (pick_any) begin
            cur        <= pick_nxt;
            rate_q     <= rate;
            xact_wbyte <= cfg_byte(conv_input(pick_nxt), rate, gain);
            sel_level  <= mux_level(pick_nxt);
            xact_req   <= 1'b1;
            xact_rd    <= 1'b0;
            st         <= ST_CFG;
          end
        end
        ST_CFG: begin
          if (xact_done) begin
            xact_req <= 1'b0;
            cnt      <= wait_len(rate_q) - 1'b1;
            st       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cnt == '0) begin
            xact_req <= 1'b1;
            xact_rd  <= 1'b1;
            st       <= ST_READ;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_READ: begin
          if (xact_done) begin
            xact_req <= 1'b0;
            xact_rd  <= 1'b0;
            if (!rd_stale) begin
              res_we   <= 1'b1;
              res_idx  <= cur;
              res_data <= rd_sample;
            end
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign idle = (st == ST_IDLE);

endmodule

// File: rtl/adc_scan_muxsel.sv
module adc_scan_muxsel #(
  parameter int NUM_PINS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          route,
  input  logic                level,
  output logic [NUM_PINS-1:0] pins
);

  // route code p+1 drives pin p; any other code leaves it low
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) pins[p] <= 1'b0;
      else     pins[p] <= (route == 2'(p + 1)) && level;
    end
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int WAIT_FAST    = 24,
  parameter int WAIT_MID     = 48,
  parameter int WAIT_SLOW    = 96,
  parameter int NUM_SEL_PINS = 2,
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 16,
  localparam int RB_W        = DATA_W + 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_we,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    xact_req,
  output logic                    xact_rd,
  output logic [7:0]              xact_wbyte,
  input  logic                    xact_done,
  input  logic [RB_W-1:0]         xact_rbytes,
  output logic [NUM_SEL_PINS-1:0] mux_pins
);

  ctrl_t             ctrl_w;
  logic [NUM_CH-1:0] mask_w;
  logic [CH_W-1:0]   cur_w;
  logic [CH_W-1:0]   nxt_w;
  logic              any_w;
  logic              idle_w;
  logic              level_w;
  logic              res_we_w;
  logic [CH_W-1:0]   res_idx_w;
  logic [DATA_W-1:0] res_data_w;
  logic              unused_status;

  assign unused_status = ^xact_rbytes[6:0];

  adc_scan_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CH(NUM_CH)
  ) i_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .ctrl(ctrl_w), .mask(mask_w),
    .res_we(res_we_w), .res_idx(res_idx_w), .res_data(res_data_w)
  );

  adc_scan_pick #(.N_CH(NUM_CH)) i_pick (
    .mask(mask_w), .cur(cur_w), .nxt(nxt_w), .any(any_w)
  );

  adc_scan_fsm #(
    .N_CH(NUM_CH), .DATA_W(DATA_W),
    .WAIT_FAST(WAIT_FAST), .WAIT_MID(WAIT_MID), .WAIT_SLOW(WAIT_SLOW)
  ) i_fsm (
    .clk(clk), .rst(rst),
    .rate(ctrl_w.rate), .gain(ctrl_w.gain),
    .pick_any(any_w), .pick_nxt(nxt_w),
    .cur(cur_w), .idle(idle_w),
    .xact_req(xact_req), .xact_rd(xact_rd), .xact_wbyte(xact_wbyte),
    .xact_done(xact_done),
    .rd_sample(xact_rbytes[RB_W-1:8]), .rd_stale(xact_rbytes[7]),
    .sel_level(level_w),
    .res_we(res_we_w), .res_idx(res_idx_w), .res_data(res_data_w)
  );

  adc_scan_muxsel #(.NUM_PINS(NUM_SEL_PINS)) i_muxsel (
    .clk(clk), .rst(rst),
    .route(ctrl_w.route), .level(level_w), .pins(mux_pins)
  );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NUM_PINS = 2,
  parameter int N_CH     = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                xact_req,
  input logic                xact_rd,
  input logic [7:0]          xact_wbyte,
  input logic                xact_done,
  input logic                rd_stale,
  input logic                res_we,
  input logic                fsm_idle,
  input logic [N_CH-1:0]     mask,
  input logic [1:0]          route,
  input logic [NUM_PINS-1:0] mux_pins
);

  // R3: an empty mask keeps the idle sequencer quiet
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (fsm_idle && mask == '0) |=> !xact_req);

  // R4: write requests carry start=1 and one-shot=0
  a_r4_cfg_layout: assert property (@(posedge clk) disable iff (rst)
    (xact_req && !xact_rd) |-> (xact_wbyte[7] && !xact_wbyte[4]));

  // R4: request payload stays put until completion
  a_r4_byte_hold: assert property (@(posedge clk) disable iff (rst)
    (xact_req && !xact_done) |=> ($stable(xact_wbyte) && $stable(xact_rd)));

  // R7: a request is held until the port completes it
  a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
    (xact_req && !xact_done) |=> xact_req);

  // R8: results are written only after a fresh read completion
  a_r8_store_gate: assert property (@(posedge clk) disable iff (rst)
    res_we |-> $past(xact_done && xact_rd && !rd_stale));

  // R5: at most one pin carries the select level
  a_r5_one_pin: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mux_pins));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_route
    // R5: a pin not chosen by the route field stays low
    a_r5_pin_route: assert property (@(posedge clk) disable iff (rst)
      ($past(route) != 2'(p + 1)) |-> !mux_pins[p]);
  end

endmodule

bind adc_scan_seq adc_scan_seq_chk #(
  .NUM_PINS(NUM_SEL_PINS), .N_CH(adc_scan_pkg::NUM_CH)
) i_chk (
  .clk(clk), .rst(rst),
  .xact_req(xact_req), .xact_rd(xact_rd), .xact_wbyte(xact_wbyte),
  .xact_done(xact_done), .rd_stale(xact_rbytes[7]),
  .res_we(res_we_w), .fsm_idle(idle_w), .mask(mask_w),
  .route(ctrl_w.route), .mux_pins(mux_pins)
);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;

  localparam int W_FAST = 24;
  localparam int W_MID  = 48;
  localparam int W_SLOW = 96;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        xact_req, xact_rd;
  logic [7:0]  xact_wbyte;
  logic        xact_done = 1'b0;
  logic [23:0] xact_rbytes = '0;
  logic [1:0]  mux_pins;

  always #5 clk = ~clk;

  adc_scan_seq #(
    .WAIT_FAST(W_FAST), .WAIT_MID(W_MID), .WAIT_SLOW(W_SLOW), .NUM_SEL_PINS(2)
  ) i_adc_scan_seq (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .xact_req(xact_req), .xact_rd(xact_rd), .xact_wbyte(xact_wbyte),
    .xact_done(xact_done), .xact_rbytes(xact_rbytes),
    .mux_pins(mux_pins)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [15:0] exp_res [6];
  bit          stale = 1'b0;
  int          n_wr = 0;
  int          n_rd = 0;
  logic [7:0]  log_cfg [64];
  logic [1:0]  log_pin [64];
  int          log_n = 0;
  int          wr_done_cyc = 0;
  int          last_gap = 0;
  logic [7:0]  last_cfg = '0;
  logic        last_lvl = 1'b0;
  int          seq = 0;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // transaction port model: completes each request two cycles after seeing it
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && xact_req) begin
        if (xact_rd) last_gap = cyc - wr_done_cyc;
        repeat (2) @(negedge clk);
        if (!xact_rd) begin
          last_cfg = xact_wbyte;
          last_lvl = |mux_pins;
          if (log_n < 64) begin
            log_cfg[log_n] = xact_wbyte;
            log_pin[log_n] = mux_pins;
            log_n++;
          end
          n_wr++;
          wr_done_cyc = cyc;
        end else begin
          int ch;
          logic [15:0] smp;
          ch = (last_cfg[6:5] < 2) ? int'(last_cfg[6:5])
                                   : 2 * int'(last_cfg[6:5]) - 2 + int'(last_lvl);
          smp = {4'(ch + 1), 12'(seq)};
          seq++;
          xact_rbytes = {smp, stale, last_cfg[6:0]};
          if (!stale) exp_res[ch] = smp;
          n_rd++;
        end
        xact_done = 1'b1;
        @(negedge clk);
        xact_done = 1'b0;
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_rd(input int target);
    while (n_rd < target) @(negedge clk);
  endtask

  task automatic stop_scan();
    wr(4'h2, 16'h0000);
    while (!(n_rd == n_wr && !xact_req)) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [1:0] in_of(input int ch);
    return (ch < 2) ? 2'(ch) : ((ch < 4) ? 2'd2 : 2'd3);
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    check(xact_req == 1'b0, "R3 reset req", 32'(xact_req), 0);
    rd(4'h0, v);
    check(v == 16'hAD00, "R1 reset id word", v, 16'hAD00);
    rd(4'h2, v);
    check(v == 16'h0000, "R2 reset mask", v, 0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr(4'h0, 16'hFFFF);
    rd(4'h0, v);
    check(v == 16'hAD3F, "R11 ctrl upper bits ignored", v, 16'hAD3F);
    wr(4'h0, 16'h0000);
    rd(4'h0, v);
    check(v == 16'hAD00, "R1 ctrl cleared", v, 16'hAD00);
    wr(4'h2, 16'hA5C0);
    rd(4'h2, v);
    check(v == 16'hA5C0, "R2 mask readback", v, 16'hA5C0);
    wr(4'h2, 16'h0000);
  endtask

  task automatic t_idle();
    int w0;
    w0 = n_wr;
    repeat (150) @(negedge clk);
    check(n_wr == w0 && !xact_req, "R3 idle with empty mask", n_wr, w0);
  endtask

  task automatic t_order();
    int order [4] = '{0, 2, 3, 5};
    log_n = 0;
    wr(4'h0, 16'h0016);
    wr(4'h2, 16'h002D);
    wait_rd(n_rd + 8);
    stop_scan();
    for (int i = 0; i < 8; i++) begin
      int ch;
      logic [7:0] ec;
      logic [1:0] ep;
      ch = order[i % 4];
      ec = {1'b1, in_of(ch), 1'b0, 2'd1, 2'd2};
      ep = {1'b0, (ch >= 2) && (ch % 2 == 1)};
      check(log_cfg[i] == ec, "R4 R6 config byte in scan order", log_cfg[i], ec);
      check(log_pin[i] == ep, "R5 select level on pin 0", log_pin[i], ep);
    end
    check(last_gap == W_MID + 1, "R7 wait for rate code 1", last_gap, W_MID + 1);
  endtask

  task automatic t_route();
    int b;
    b = log_n;
    wr(4'h0, 16'h0020);
    wr(4'h2, 16'h0008);
    wait_rd(n_rd + 2);
    stop_scan();
    check(log_pin[b] == 2'b10, "R5 route 2 uses pin 1", log_pin[b], 2'b10);
    check(log_cfg[b] == 8'hC0, "R4 channel 4 config", log_cfg[b], 8'hC0);
    check(last_gap == W_FAST + 1, "R7 wait for rate code 0", last_gap, W_FAST + 1);
    b = log_n;
    wr(4'h0, 16'h0008);
    wr(4'h2, 16'h0008);
    wait_rd(n_rd + 2);
    stop_scan();
    check(log_pin[b] == 2'b00, "R5 route 0 keeps pins low", log_pin[b], 0);
    check(last_gap == W_SLOW + 1, "R7 wait for rate code 2", last_gap, W_SLOW + 1);
  endtask

  task automatic t_results();
    logic [15:0] v;
    logic [15:0] snap [6];
    wr(4'h0, 16'h0010);
    wr(4'h2, 16'h003F);
    wait_rd(n_rd + 12);
    stop_scan();
    for (int i = 0; i < 6; i++) begin
      rd(4'(4 + 2 * i), v);
      check(v == exp_res[i], "R8 stored sample", v, exp_res[i]);
      snap[i] = v;
    end
    wr(4'h2, 16'h0001);
    wait_rd(n_rd + 3);
    stop_scan();
    rd(4'h4, v);
    check(v == exp_res[0] && v != snap[0], "R9 enabled channel refreshed", v, exp_res[0]);
    for (int i = 1; i < 6; i++) begin
      rd(4'(4 + 2 * i), v);
      check(v == snap[i], "R9 masked channel keeps value", v, snap[i]);
    end
  endtask

  task automatic t_stale();
    logic [15:0] v;
    stale = 1'b1;
    wr(4'h2, 16'h003F);
    wait_rd(n_rd + 6);
    stop_scan();
    stale = 1'b0;
    for (int i = 0; i < 6; i++) begin
      rd(4'(4 + 2 * i), v);
      check(v == exp_res[i], "R8 stale status discarded", v, exp_res[i]);
    end
  endtask

  task automatic t_read_only();
    logic [15:0] v;
    wr(4'h4, 16'hDEAD);
    wr(4'hE, 16'hBEEF);
    rd(4'h4, v);
    check(v == exp_res[0], "R11 write to channel 1 result ignored", v, exp_res[0]);
    rd(4'hE, v);
    check(v == exp_res[5], "R11 write to channel 6 result ignored", v, exp_res[5]);
  endtask

  task automatic t_midflight();
    int w0, r0;
    wr(4'h2, 16'h003F);
    forever begin
      @(posedge clk);
      #1;
      if (xact_req && !xact_rd && !xact_done) break;
    end
    w0 = n_wr;
    r0 = n_rd;
    stop_scan();
    check(n_wr == w0 + 1, "R10 in-flight write finishes, no new channel", n_wr, w0 + 1);
    check(n_rd == r0 + 1, "R10 in-flight channel still read", n_rd, r0 + 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_idle();
    t_order();
    t_route();
    t_results();
    t_stale();
    t_read_only();
    t_midflight();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule